// File: doc/BRIEF.md
# Modem Line Status and Interrupt Flag

This block holds the eight-bit status word of a serial port and drives its interrupt request. Two active-low modem lines, carrier detect and set-ready, are brought through a synchronizer and copied into the status word. When one of them changes while interrupts are globally enabled, the copied levels are held and the interrupt flag is set. The held levels stay put, whatever the lines do, until the host reads the status word. That read clears the flag and compares the lines again. If they have moved since the hold began, the new levels are captured and the flag is set again straight away.

The receiver and the transmitter each supply a one-cycle event pulse, which also sets the flag while interrupts are enabled. They also supply level inputs for the receive-full and transmit-empty bits. The three receive error inputs are passed through to the status word and never raise the flag. The request pin is active low and follows the flag.

Top module: `modem_status_irq`

## Requirements
- R1: The status word carries parity error in bit 0, framing error in bit 1, overrun in bit 2, receive-full in bit 3 and transmit-empty in bit 4, each taken from its input in the same cycle.
- R2: Bit 5 shows the carrier-detect line and bit 6 the set-ready line, 0 for a low input and 1 for a high one. A line change reaches the status word no later than the third rising clock edge after it.
- R3: A captured change on either modem line sets the interrupt flag (bit 7) when the global enable is 1. With the enable at 0, no flag is set and bits 5 and 6 simply follow the lines.
- R4: After a change has set the flag, bits 5 and 6 hold the captured levels until a status read, regardless of later line activity.
- R5: On a status read, if the synchronized lines differ from bits 5 and 6 and the enable is 1, the new levels are captured and the flag is 1 in the cycle after the read.
- R6: A status read with no interrupt event in the same cycle leaves the flag at 0 after the clock edge. The request output is low exactly when bit 7 is 1.
- R7: A receive event or transmit event pulse sets the flag when the enable is 1 and has no effect when it is 0.
- R8: The three error inputs never set the interrupt flag.
- R9: If an interrupt event and a status read fall in the same cycle, the flag remains 1.
- R10: After reset the flag is 0, the request output is high, and bits 5 and 6 read 1 with no hold in force.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| irq_en | input | 1 | Global interrupt enable |
| dcd_n_i | input | 1 | Carrier-detect line, active low, asynchronous |
| dsr_n_i | input | 1 | Set-ready line, active low, asynchronous |
| stat_rd | input | 1 | One-cycle strobe: the host reads the status word in this cycle |
| rx_full | input | 1 | Receive data holding register full |
| tx_empty | input | 1 | Transmit data holding register empty |
| rx_evt | input | 1 | One-cycle receive interrupt event |
| tx_evt | input | 1 | One-cycle transmit interrupt event |
| err_par | input | 1 | Parity error level |
| err_frm | input | 1 | Framing error level |
| err_ovr | input | 1 | Overrun level |
| status | output | 8 | Status word |
| irq_n | output | 1 | Interrupt request, active low |

## Verification
If the hold flag is wrong, it shows up in two ways. One is a second line change that appears in bits 5 and 6 before any read. The other is a change that fails to appear after a read. Either one is visible four clocks after the line moves. A flag that fails to clear, or clears too eagerly, shows on the request pin on the first clock edge after the read strobe or event pulse. Errors in the bit layout are visible in the same cycle as the input combination that exposes them, so a sweep over all thirty-two combinations of the pass-through inputs covers them.

// File: rtl/ms_pkg.sv
package ms_pkg;
  localparam int STAT_W  = 8;
  localparam int LINES_W = 2;
  localparam int B_PAR   = 0;
  localparam int B_FRM   = 1;
  localparam int B_OVR   = 2;
  localparam int B_RXF   = 3;
  localparam int B_TXE   = 4;
  localparam int B_DCD   = 5;
  localparam int B_DSR   = 6;
  localparam int B_IRQ   = 7;
  localparam int L_DCD   = 0;
  localparam int L_DSR   = 1;
endpackage

// File: rtl/ms_sync.sv
module ms_sync #(
  parameter int             W       = 1,
  parameter int             STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[i] <= RST_VAL;
        else        chain[i] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[i] <= RST_VAL;
        else        chain[i] <= chain[i-1];
      end
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/ms_modem_latch.sv
module ms_modem_latch #(
  parameter int W = ms_pkg::LINES_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         rd,
  input  logic [W-1:0] lines_s,
  output logic [W-1:0] lines_q,
  output logic         frozen_q,
  output logic         modem_evt
);
  logic [W-1:0] lines_d;
  logic         frozen_d;
  logic         changed;
  logic         looking;
  logic         load;

  always_comb begin
    changed   = (lines_s != lines_q);
    looking   = !frozen_q || rd;
    load      = looking && changed;
    lines_d   = lines_q;
    frozen_d  = frozen_q;
    modem_evt = 1'b0;
    if (rd) frozen_d = 1'b0;
    if (load) begin
      lines_d = lines_s;
      if (en) begin
        modem_evt = 1'b1;
        frozen_d  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    lines_q <= '1;
    else if (load) lines_q <= lines_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) frozen_q <= 1'b0;
    else        frozen_q <= frozen_d;
  end
endmodule

// File: rtl/ms_irq_flag.sv
module ms_irq_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_evt,
  input  logic rd,
  output logic irq_q
);
  logic irq_d;
  logic upd;

  always_comb begin
    upd   = set_evt || rd;
    irq_d = set_evt ? 1'b1 : 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   irq_q <= 1'b0;
    else if (upd) irq_q <= irq_d;
  end
endmodule

// File: rtl/modem_status_irq.sv
module modem_status_irq #(
  parameter int SYNC_STAGES = 2,
  parameter int RST_STAGES  = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       irq_en,
  input  logic       dcd_n_i,
  input  logic       dsr_n_i,
  input  logic       stat_rd,
  input  logic       rx_full,
  input  logic       tx_empty,
  input  logic       rx_evt,
  input  logic       tx_evt,
  input  logic       err_par,
  input  logic       err_frm,
  input  logic       err_ovr,
  output logic [7:0] status,
  output logic       irq_n
);
  import ms_pkg::*;

  logic               rst_n_q;
  logic [LINES_W-1:0] lines_raw;
  logic [LINES_W-1:0] lines_s;
  logic [LINES_W-1:0] lines_q;
  logic               frozen_q;
  logic               modem_evt;
  logic               set_evt;
  logic               irq_q;

  ms_sync #(.W(1), .STAGES(RST_STAGES), .RST_VAL(1'b0)) u_rst_sync (
    .clk(clk), .rst_n(rst_n), .d(1'b1), .q(rst_n_q)
  );

  always_comb begin
    lines_raw        = '0;
    lines_raw[L_DCD] = dcd_n_i;
    lines_raw[L_DSR] = dsr_n_i;
  end

  ms_sync #(.W(LINES_W), .STAGES(SYNC_STAGES), .RST_VAL({LINES_W{1'b1}})) u_line_sync (
    .clk(clk), .rst_n(rst_n_q), .d(lines_raw), .q(lines_s)
  );

  ms_modem_latch #(.W(LINES_W)) u_latch (
    .clk(clk), .rst_n(rst_n_q), .en(irq_en), .rd(stat_rd),
    .lines_s(lines_s), .lines_q(lines_q), .frozen_q(frozen_q), .modem_evt(modem_evt)
  );

  always_comb set_evt = modem_evt || (irq_en && (rx_evt || tx_evt));

  ms_irq_flag u_irq (
    .clk(clk), .rst_n(rst_n_q), .set_evt(set_evt), .rd(stat_rd), .irq_q(irq_q)
  );

  always_comb begin
    status        = '0;
    status[B_PAR] = err_par;
    status[B_FRM] = err_frm;
    status[B_OVR] = err_ovr;
    status[B_RXF] = rx_full;
    status[B_TXE] = tx_empty;
    status[B_DCD] = lines_q[L_DCD];
    status[B_DSR] = lines_q[L_DSR];
    status[B_IRQ] = irq_q;
    irq_n         = ~irq_q;
  end
endmodule

// File: rtl/ms_status_chk.sv
module ms_status_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       irq_en,
  input logic       stat_rd,
  input logic       rx_evt,
  input logic       tx_evt,
  input logic       frozen,
  input logic       modem_evt,
  input logic [1:0] lines_s,
  input logic [7:0] status
);
  logic unit_evt;
  assign unit_evt = irq_en && (rx_evt || tx_evt);

  p_disabled_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_en && !status[7]) |=> !status[7]);

  p_modem_evt_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
    modem_evt |=> status[7]);

  p_frozen_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (frozen && !stat_rd) |=> $stable(status[6:5]));

  p_read_recheck_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && irq_en && (lines_s != status[6:5])) |=> (status[7] && status[6:5] == $past(lines_s)));

  p_read_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !modem_evt && !unit_evt) |=> !status[7]);

  p_unit_evt_r7: assert property (@(posedge clk) disable iff (!rst_n)
    unit_evt |=> status[7]);

  p_rise_has_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[7]) |-> $past(modem_evt || unit_evt));

  p_read_race_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && (modem_evt || unit_evt)) |=> status[7]);
endmodule

bind modem_status_irq ms_status_chk u_chk (
  .clk(clk), .rst_n(rst_n_q), .irq_en(irq_en), .stat_rd(stat_rd),
  .rx_evt(rx_evt), .tx_evt(tx_evt), .frozen(frozen_q), .modem_evt(modem_evt),
  .lines_s(lines_s), .status(status)
);

// File: tb/modem_status_irq_bench.sv
module modem_status_irq_bench;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rst_n, irq_en, dcd_n_i, dsr_n_i, stat_rd;
  logic       rx_full, tx_empty, rx_evt, tx_evt, err_par, err_frm, err_ovr;
  logic [7:0] status;
  logic       irq_n;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  modem_status_irq u_modem_status_irq (
    .clk(clk), .rst_n(rst_n), .irq_en(irq_en), .dcd_n_i(dcd_n_i), .dsr_n_i(dsr_n_i),
    .stat_rd(stat_rd), .rx_full(rx_full), .tx_empty(tx_empty), .rx_evt(rx_evt),
    .tx_evt(tx_evt), .err_par(err_par), .err_frm(err_frm), .err_ovr(err_ovr),
    .status(status), .irq_n(irq_n)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd_pulse();
    stat_rd = 1'b1;
    tick(1);
    stat_rd = 1'b0;
  endtask

  task automatic set_lines(input logic [1:0] p);
    dsr_n_i = p[1];
    dcd_n_i = p[0];
  endtask

  // Upper three status bits: {irq, dsr, dcd}
  function automatic logic [7:0] top3(input logic irq, input logic [1:0] p);
    return {5'b0, irq, p};
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [1:0] cur;
    rst_n = 1'b0; irq_en = 1'b0; dcd_n_i = 1'b1; dsr_n_i = 1'b1; stat_rd = 1'b0;
    rx_full = 1'b0; tx_empty = 1'b0; rx_evt = 1'b0; tx_evt = 1'b0;
    err_par = 1'b0; err_frm = 1'b0; err_ovr = 1'b0;
    tick(3);
    rst_n = 1'b1;
    tick(4);

    // R10 reset state
    check("R10 status", status, 8'h60);
    check("R10 irq_n", {7'b0, irq_n}, 8'h01);

    // R1 R8 sweep over all pass-through combinations, interrupts enabled
    irq_en = 1'b1;
    for (int v = 0; v < 32; v++) begin
      {tx_empty, rx_full, err_ovr, err_frm, err_par} = v[4:0];
      tick(1);
      check("R1 R8 layout", status, {3'b011, v[4:0]});
    end
    {tx_empty, rx_full, err_ovr, err_frm, err_par} = 5'b0;
    tick(1);

    // R2 R3 R4 R5 R6 modem sweep
    cur = 2'b11;
    for (int en = 0; en < 2; en++) begin
      for (int pi = 0; pi < 4; pi++) begin
        logic [1:0] p;
        logic       hit;
        p      = pi[1:0];
        irq_en = en[0];
        set_lines(p);
        tick(4);
        hit = (p != cur) && en[0];
        check("R2 R3 modem change", status[7:5], top3(hit, p));
        check("R6 pin", {7'b0, irq_n}, {7'b0, ~hit});
        if (hit) begin
          set_lines(~p);
          tick(4);
          check("R4 hold", status[7:5], top3(1'b1, p));
          rd_pulse();
          check("R5 recheck", status[7:5], top3(1'b1, ~p));
          rd_pulse();
          check("R6 clear", status[7:5], top3(1'b0, ~p));
          cur = ~p;
        end else begin
          rd_pulse();
          check("R6 clear quiet", status[7:5], top3(1'b0, p));
          cur = p;
        end
      end
    end

    // R4 hold released by a read with no line change
    irq_en = 1'b1;
    set_lines(~cur);
    tick(4);
    check("R4 set", status[7:5], top3(1'b1, ~cur));
    rd_pulse();
    check("R4 read no change", status[7:5], top3(1'b0, ~cur));
    set_lines(cur);
    tick(4);
    check("R4 released", status[7:5], top3(1'b1, cur));
    rd_pulse();
    check("R6 clear", status[7], 1'b0);

    // R7 unit events
    rx_evt = 1'b1; tick(1); rx_evt = 1'b0;
    check("R7 rx event", {7'b0, status[7]}, 8'h01);
    rd_pulse();
    check("R6 clear after rx", {7'b0, status[7]}, 8'h00);
    tx_evt = 1'b1; tick(1); tx_evt = 1'b0;
    check("R7 tx event", {7'b0, irq_n}, 8'h00);
    rd_pulse();
    irq_en = 1'b0;
    rx_evt = 1'b1; tick(1); rx_evt = 1'b0;
    check("R7 rx disabled", {7'b0, status[7]}, 8'h00);
    tx_evt = 1'b1; tick(1); tx_evt = 1'b0;
    check("R7 tx disabled", {7'b0, status[7]}, 8'h00);

    // R9 read and event in the same cycle
    irq_en = 1'b1;
    rx_evt = 1'b1; stat_rd = 1'b1; tick(1); rx_evt = 1'b0; stat_rd = 1'b0;
    check("R9 race from clear", {7'b0, status[7]}, 8'h01);
    tx_evt = 1'b1; stat_rd = 1'b1; tick(1); tx_evt = 1'b0; stat_rd = 1'b0;
    check("R9 race from set", {7'b0, status[7]}, 8'h01);
    rd_pulse();
    check("R6 clear after race", {7'b0, status[7]}, 8'h00);

    // R8 error inputs toggled with interrupts enabled
    for (int e = 0; e < 8; e++) begin
      {err_ovr, err_frm, err_par} = e[2:0];
      tick(2);
      check("R8 no irq", {7'b0, irq_n}, 8'h01);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule